// File: doc/BRIEF.md
# Level-Sensitive Interrupt Gateway and Claim/Complete Controller

This block collects level-sensitive interrupt requests from a set of sources and routes them to a set of targets, such as harts or privilege contexts. Each source feeds a gateway that synchronizes the input and latches a request into a pending bit. Once a source has been claimed, its gateway refuses new requests until software signals completion. Each source has a priority. Each target has an enable mask, a threshold and a claim/complete register. Each target drives one interrupt line. That line is raised while some pending source is enabled for the target and has a priority above the target's threshold.

Software reads the target's claim/complete register to take the best eligible source. The read returns the source ID and clears that source's pending bit. When the handler has really finished, software writes the same ID back to the register. If the source is still asserted at that point, the gateway forwards a fresh request. Completing early can therefore produce a second interrupt.

Top module: `plic_core`

## Requirements
- R1: After reset every interrupt output is 0, the pending vector reads 0 and every priority reads 0.
- R2: Once a gateway has latched a request, the pending bit stays set after the source input falls, until that source is claimed.
- R3: A claim read returns the ID of the pending source enabled for that target with the highest priority. Equal priorities go to the lowest ID. The claimed source's pending bit is cleared.
- R4: After a claim, the source's pending bit is not set again, for any target, until a valid completion for that source arrives. This holds even while the input stays high.
- R5: If the source input is still high when a valid completion arrives, the source becomes pending again and the interrupt is raised again.
- R6: A source with priority 0 never raises any output and is never returned by a claim, whatever the enables.
- R7: A completion write is ignored, and the gateway stays closed, when the written ID is 0, is above the source count, is not currently claimed, or was claimed through a different target.
- R8: A claim read with no eligible source returns 0 and changes no pending state.
- R9: A source is eligible for a target only if its priority is strictly greater than that target's threshold.
- R10: A priority write takes effect on the interrupt outputs in the cycle after the write is accepted, with no other event needed.
- R11: The address byte is split into kind = addr[7:5] and index = addr[4:0]. The kinds are: 0 priority of source ID index; 1 enable mask of target index; 2 threshold of target index; 3 claim (read) or complete (write, data = ID) for target index; 4 pending vector (read only). Read data appears on rd_data_o one cycle after the request. In the enable mask and the pending vector, bit k stands for source ID k, and bit 0 is always 0. Input src_i[k-1] is source ID k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level interrupt inputs; bit k-1 is source ID k |
| req_valid_i | input | 1 | Register access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Register address (kind and index) |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid one cycle after a read |
| irq_o | output | NTGT | One interrupt line per target |

## Verification
The bench drops a source after it has become pending and confirms the request is still delivered. It holds a claimed source high and confirms that no new pending bit appears. A gateway that reopened early would show the bit again and interrupt a second time. Completions are sent through the wrong target, with unclaimed IDs and with out-of-range IDs, and must leave the gateway closed; a lax ID check would reopen it. Tied priorities must resolve to the lower ID. A threshold equal to a priority must block that source. A source at priority 0 must stay silent until a priority write raises the line in the next cycle; a design that only re-evaluated on source events would stay stuck low.

// File: rtl/plic_pkg.sv
package plic_pkg;
  typedef enum logic [2:0] {
    KIND_PRIO  = 3'd0,
    KIND_EN    = 3'd1,
    KIND_THR   = 3'd2,
    KIND_CLAIM = 3'd3,
    KIND_PEND  = 3'd4
  } reg_kind_e;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic busy_o
);
  logic s1_q, s2_q;
  logic pend_q, pend_d, busy_q, busy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= lvl_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (claim_i && pend_q) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end else if (done_i && busy_q) begin
      busy_d = 1'b0;
    end else if (s2_q && !busy_q && !pend_q) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
  parameter int NSRC   = 7,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC + 1)
) (
  input  logic [NSRC:0]             pend_i,
  input  logic [NSRC:0]             en_i,
  input  logic [NSRC:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic [ID_W-1:0]           id_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p = thr_i;
    id_o   = '0;
    for (int k = 1; k <= NSRC; k++) begin
      if (pend_i[k] && en_i[k] && (prio_i[k] > best_p)) begin
        best_p = prio_i[k];
        id_o   = ID_W'(k);
      end
    end
  end
endmodule

// File: rtl/plic_core.sv
module plic_core #(
  parameter int NSRC   = 7,
  parameter int NTGT   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int ID_W  = $clog2(NSRC + 1),
  localparam int IDX_W = ADDR_W - 3,
  localparam int TGT_W = (NTGT > 1) ? $clog2(NTGT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NTGT-1:0]   irq_o
);
  import plic_pkg::*;

  logic rst_m_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q   <= rst_m_q;
    end
  end

  logic [NSRC:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NTGT-1:0][NSRC:0]   en_q, en_d;
  logic [NTGT-1:0][PRIO_W-1:0] thr_q, thr_d;
  logic [NSRC:0][TGT_W-1:0]  owner_q, owner_d;
  logic [DATA_W-1:0]         rd_q, rd_d;
  logic [NTGT-1:0][ID_W-1:0] best_id;
  logic [NSRC:0]             pend, busy, claim_vec, cmpl_vec;

  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  assign kind = reg_kind_e'(req_addr_i[ADDR_W-1:IDX_W]);
  assign idx  = req_addr_i[IDX_W-1:0];

  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;

  for (genvar k = 1; k <= NSRC; k++) begin : g_src
    plic_gateway i_gw (
      .clk    (clk),
      .rst_n  (rst_q),
      .lvl_i  (src_i[k-1]),
      .claim_i(claim_vec[k]),
      .done_i (cmpl_vec[k]),
      .pend_o (pend[k]),
      .busy_o (busy[k])
    );
  end

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    plic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) i_arb (
      .pend_i(pend),
      .en_i  (en_q[t]),
      .prio_i(prio_q),
      .thr_i (thr_q[t]),
      .id_o  (best_id[t])
    );
    assign irq_o[t] = (best_id[t] != '0);
  end

  logic rd_en, wr_en;
  assign rd_en = req_valid_i && !req_write_i;
  assign wr_en = req_valid_i &&  req_write_i;

  always_comb begin
    prio_d    = prio_q;
    en_d      = en_q;
    thr_d     = thr_q;
    owner_d   = owner_q;
    rd_d      = rd_q;
    claim_vec = '0;
    cmpl_vec  = '0;
    if (rd_en) rd_d = '0;
    case (kind)
      KIND_PRIO: begin
        for (int k = 1; k <= NSRC; k++) begin
          if (idx == IDX_W'(k)) begin
            if (wr_en) prio_d[k] = req_wdata_i[PRIO_W-1:0];
            if (rd_en) rd_d[PRIO_W-1:0] = prio_q[k];
          end
        end
      end
      KIND_EN: begin
        for (int t = 0; t < NTGT; t++) begin
          if (idx == IDX_W'(t)) begin
            if (wr_en) en_d[t] = {req_wdata_i[NSRC:1], 1'b0};
            if (rd_en) rd_d[NSRC:0] = en_q[t];
          end
        end
      end
      KIND_THR: begin
        for (int t = 0; t < NTGT; t++) begin
          if (idx == IDX_W'(t)) begin
            if (wr_en) thr_d[t] = req_wdata_i[PRIO_W-1:0];
            if (rd_en) rd_d[PRIO_W-1:0] = thr_q[t];
          end
        end
      end
      KIND_CLAIM: begin
        for (int t = 0; t < NTGT; t++) begin
          if (idx == IDX_W'(t)) begin
            if (rd_en) begin
              rd_d[ID_W-1:0] = best_id[t];
              for (int k = 1; k <= NSRC; k++) begin
                if (best_id[t] == ID_W'(k)) begin
                  claim_vec[k] = 1'b1;
                  owner_d[k]   = TGT_W'(t);
                end
              end
            end
            if (wr_en) begin
              for (int k = 1; k <= NSRC; k++) begin
                if ((req_wdata_i == DATA_W'(k)) && busy[k] &&
                    (owner_q[k] == TGT_W'(t)))
                  cmpl_vec[k] = 1'b1;
              end
            end
          end
        end
      end
      KIND_PEND: begin
        if (rd_en) rd_d[NSRC:0] = pend;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      owner_q <= '0;
      rd_q    <= '0;
    end else begin
      prio_q  <= prio_d;
      en_q    <= en_d;
      thr_q   <= thr_d;
      owner_q <= owner_d;
      rd_q    <= rd_d;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
  parameter int NSRC   = 7,
  parameter int NTGT   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                      clk,
  input logic                      rst_q,
  input logic [NSRC:0]             pend,
  input logic [NSRC:0]             busy,
  input logic [NSRC:0]             claim_vec,
  input logic [NSRC:0]             cmpl_vec,
  input logic [NSRC:0][PRIO_W-1:0] prio_q,
  input logic                      req_valid_i,
  input logic                      req_write_i,
  input logic [ADDR_W-1:0]         req_addr_i,
  input logic [DATA_W-1:0]         rd_data_o,
  input logic [NTGT-1:0]           irq_o
);
  localparam int IDX_W = ADDR_W - 3;

  for (genvar k = 1; k <= NSRC; k++) begin : g_s
    assert_pend_survives_R2: assert property (@(posedge clk) disable iff (!rst_q)
      (pend[k] && !claim_vec[k]) |=> pend[k]);
    assert_gate_closed_R4: assert property (@(posedge clk) disable iff (!rst_q)
      (busy[k] && !cmpl_vec[k]) |=> (busy[k] && !pend[k]));
    assert_reopen_on_done_R7: assert property (@(posedge clk) disable iff (!rst_q)
      $fell(busy[k]) |-> $past(cmpl_vec[k]));
  end

  assert_prio_zero_quiet_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (prio_q == '0) |-> (irq_o == '0));

  for (genvar t = 0; t < NTGT; t++) begin : g_t
    assert_empty_claim_R8: assert property (@(posedge clk) disable iff (!rst_q)
      (req_valid_i && !req_write_i && (req_addr_i[ADDR_W-1:IDX_W] == 3'd3) &&
       (req_addr_i[IDX_W-1:0] == IDX_W'(t)) && !irq_o[t]) |=> (rd_data_o == '0));
  end
endmodule

bind plic_core plic_core_chk #(
  .NSRC(NSRC), .NTGT(NTGT), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst_q(rst_q), .pend(pend), .busy(busy), .claim_vec(claim_vec),
  .cmpl_vec(cmpl_vec), .prio_q(prio_q), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_addr_i(req_addr_i), .rd_data_o(rd_data_o),
  .irq_o(irq_o)
);

// File: tb/test_plic_core.sv
module test_plic_core;
  localparam int NSRC = 7;
  localparam int NTGT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] src;
  logic req_valid, req_write;
  logic [7:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic [NTGT-1:0] irq;

  always #2.5 clk = ~clk;

  plic_core i_plic_core (
    .clk(clk), .rst_n(rst_n), .src_i(src), .req_valid_i(req_valid),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  // op: 0 write, 1 read+compare, 2 drive sources and settle, 3 compare irq
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h03, 32'd5,    32'd0,    8'd11}, // prio id3 = 5
    '{2'd0, 8'h05, 32'd5,    32'd0,    8'd11}, // prio id5 = 5
    '{2'd0, 8'h02, 32'd2,    32'd0,    8'd11}, // prio id2 = 2
    '{2'd1, 8'h03, 32'd0,    32'd5,    8'd11}, // R11 readback
    '{2'd0, 8'h20, 32'h2C,   32'd0,    8'd11}, // en t0 = ids 2,3,5
    '{2'd0, 8'h21, 32'h20,   32'd0,    8'd11}, // en t1 = id 5
    '{2'd0, 8'h41, 32'd4,    32'd0,    8'd11}, // thr t1 = 4
    '{2'd1, 8'h21, 32'd0,    32'h20,   8'd11}, // R11 enable readback
    '{2'd2, 8'h00, 32'h16,   32'd0,    8'd2},  // raise ids 2,3,5
    '{2'd1, 8'h80, 32'd0,    32'h2C,   8'd2},  // R2 pending
    '{2'd3, 8'h00, 32'd0,    32'd3,    8'd3},  // R3 both lines
    '{2'd1, 8'h60, 32'd0,    32'd3,    8'd3},  // R3 tie -> lowest id 3
    '{2'd1, 8'h80, 32'd0,    32'h24,   8'd3},  // R3 id3 cleared
    '{2'd2, 8'h00, 32'h00,   32'd0,    8'd2},  // drop all sources
    '{2'd1, 8'h80, 32'd0,    32'h24,   8'd2},  // R2 survive deassert
    '{2'd1, 8'h61, 32'd0,    32'd5,    8'd9},  // R9 5 > thr 4
    '{2'd3, 8'h00, 32'd0,    32'd1,    8'd3},  // R3 t0 only
    '{2'd1, 8'h61, 32'd0,    32'd0,    8'd8},  // R8 empty claim
    '{2'd1, 8'h80, 32'd0,    32'h04,   8'd8},  // R8 no side effect
    '{2'd0, 8'h40, 32'd2,    32'd0,    8'd9},  // thr t0 = 2
    '{2'd3, 8'h00, 32'd0,    32'd0,    8'd9},  // R9 equal blocks
    '{2'd1, 8'h60, 32'd0,    32'd0,    8'd9},  // R9 claim empty
    '{2'd0, 8'h40, 32'd1,    32'd0,    8'd9},  // thr t0 = 1
    '{2'd3, 8'h00, 32'd0,    32'd1,    8'd9},  // R9 2 > 1
    '{2'd1, 8'h60, 32'd0,    32'd2,    8'd3},  // R3 claim id2
    '{2'd1, 8'h80, 32'd0,    32'h00,   8'd3},  // R3 all clear
    '{2'd3, 8'h00, 32'd0,    32'd0,    8'd3},  // R3 lines low
    '{2'd1, 8'h05, 32'd0,    32'd5,    8'd11}  // R11 prio readback
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic settle(input logic [NSRC-1:0] s);
    @(negedge clk);
    src = s;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    acc(1'b0, 8'h80, 0); check("R1 pending", rd_data, 32'd0);
    acc(1'b0, 8'h03, 0); check("R1 prio", rd_data, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: acc(1'b1, VEC[i].addr, VEC[i].data);
        2'd1: begin acc(1'b0, VEC[i].addr, 0); check(rq, rd_data, VEC[i].exp); end
        2'd2: settle(VEC[i].data[NSRC-1:0]);
        default: check(rq, 32'(irq), VEC[i].exp);
      endcase
    end

    // ids 3 (t0), 5 (t1), 2 (t0) are claimed now
    settle(7'h04);                      // hold id3 high
    acc(1'b0, 8'h80, 0); check("R4 blocked while claimed", rd_data, 32'h0);
    acc(1'b1, 8'h61, 32'd3);            // R7 wrong target
    repeat (4) @(negedge clk);
    acc(1'b0, 8'h80, 0); check("R7 wrong target", rd_data, 32'h0);
    acc(1'b1, 8'h60, 32'd7);            // R7 not claimed
    acc(1'b1, 8'h60, 32'd0);            // R7 id 0
    acc(1'b1, 8'h60, 32'd11);           // R7 out of range (low bits = 3)
    repeat (4) @(negedge clk);
    acc(1'b0, 8'h80, 0); check("R7 bad ids", rd_data, 32'h0);
    check("R7 irq low", 32'(irq), 32'd0);
    acc(1'b1, 8'h60, 32'd3);            // valid completion
    repeat (4) @(negedge clk);
    acc(1'b0, 8'h80, 0); check("R5 re-pend", rd_data, 32'h08);
    check("R5 irq again", 32'(irq), 32'd1);
    acc(1'b0, 8'h60, 0); check("R5 claim again", rd_data, 32'd3);
    settle(7'h00);
    acc(1'b1, 8'h60, 32'd3);
    repeat (4) @(negedge clk);
    acc(1'b0, 8'h80, 0); check("R2 quiet after done", rd_data, 32'h0);

    // priority zero mask and re-evaluation on priority write
    acc(1'b1, 8'h20, 32'h6C);
    settle(7'h20);                      // id6 high, prio 0
    acc(1'b0, 8'h80, 0); check("R6 pending set", rd_data, 32'h40);
    check("R6 masked irq", 32'(irq), 32'd0);
    acc(1'b0, 8'h60, 0); check("R6 claim empty", rd_data, 32'd0);
    acc(1'b1, 8'h06, 32'd3);
    check("R10 raise on prio write", 32'(irq), 32'd1);
    acc(1'b1, 8'h06, 32'd0);
    check("R10 drop on prio write", 32'(irq), 32'd0);
    acc(1'b1, 8'h06, 32'd3);
    acc(1'b0, 8'h60, 0); check("R10 claim id6", rd_data, 32'd6);

    finish_run();
  end
endmodule